// File: doc/BRIEF.md
# PCM Serial Port with Clock Generator

This block is the serial edge of a voice-processing core that talks to a PCM codec. From the master clock it derives a bit clock and an 8 kHz frame strobe for the codec. It also runs a receive and a transmit path for each of two 8-bit serial channels. The bit clock and frame strobe that time the channels come either from this internal divider or from two external pins. The external clock may run anywhere from 64 kHz to 2048 kHz. Everything inside runs on the master clock: the selected bit clock and frame strobe are resynchronised, and their edges are detected as one-cycle pulses.

A frame begins when the frame strobe is high at a falling bit-clock edge. The eight falling edges after it sample the inputs, most significant bit first. After the eighth one, both received bytes are presented to the core together with a single-cycle load strobe, which the core uses as its frame interrupt. The transmit bytes are captured from the core when the frame starts. They are shifted out on the rising bit-clock edges, so each bit is settled before the far end samples it on the falling edge. The serial outputs are enabled only for those eight bit periods. Companding is left to the core.

Top module: `pcm_serial_port`

## Requirements
- R1: With the default divide of 75, the generated bit clock has a period of 75 master-clock cycles and is high for the first 37 of them.
- R2: The generated frame strobe repeats every 32 bit periods (2400 master cycles). It is high for exactly one bit period, and it rises in the same cycle as a rising edge of the generated bit clock.
- R3: A falling bit-clock edge with the frame strobe high, while no reception is in progress, starts a frame. The next 8 falling edges sample each serial input, with the first bit sampled as bit 7. Lane 0 is `sd_in[0]` → `rx_bytes[7:0]` and lane 1 is `sd_in[1]` → `rx_bytes[15:8]`.
- R4: After the eighth sample, `load_o` is high for exactly one master cycle, once per frame. The received bytes on `rx_bytes` take their new value in that same cycle and hold it until the next load.
- R5: Transmit bit 7 is driven from the first rising bit-clock edge after the frame start, and each later rising edge moves to the next lower bit. The transmit bytes (`tx_bytes[7:0]` for lane 0, `tx_bytes[15:8]` for lane 1) are taken as they stand at the frame start. Changes made later in the frame do not affect it.
- R6: Each `sd_oe` bit is high for exactly the 8 bit periods that carry data and low at all other times. Each `sd_out` bit is 0 while its enable is low.
- R7: When `ext_clk_sel` is 1, the external bit clock and frame strobe time both channels, at any rate from 64 kHz to 2048 kHz. The generated clock outputs keep running.
- R8: During reset, `bclk_o`, `fsync_o`, `sd_oe`, `sd_out` and `load_o` are 0 and `rx_bytes` is 0.
- R9: A frame strobe seen at a falling edge while a reception is still in progress is ignored. It neither restarts the frame nor adds a load strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock (19.2 MHz) |
| rst_n | input | 1 | active-low reset |
| ext_clk_sel | input | 1 | 1 selects the external bit clock and frame strobe |
| bclk_in | input | 1 | external bit clock |
| fsync_in | input | 1 | external frame strobe |
| bclk_o | output | 1 | generated bit clock to the codec |
| fsync_o | output | 1 | generated frame strobe to the codec |
| sd_in | input | NLANES | serial data inputs |
| sd_out | output | NLANES | serial data outputs |
| sd_oe | output | NLANES | output enables for the serial outputs |
| tx_bytes | input | NLANES*WORD_W | bytes to transmit, lane 0 in the low byte |
| rx_bytes | output | NLANES*WORD_W | received bytes, lane 0 in the low byte |
| load_o | output | 1 | one-cycle strobe when the received bytes are ready |

## Verification
Frames on the internal clock use the all-zero, all-one, alternating and single-set-bit byte patterns on both lanes at once. These patterns expose bit-order reversal, a slip by one bit and crosstalk between lanes. In a sweep on an external 1.92 MHz clock, every receive value is sent on lane 0 with its complement on lane 1, and an unrelated transmit pattern goes the other way. This shows that every bit position passes in both directions. Slow 64 kHz frames test the low end of the range. Further frames carry a stray frame strobe in mid-frame or a transmit byte that changes after the frame has started, to show that each is ignored.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

   // one-cycle pulses marking bit-clock transitions in the master domain
   typedef struct packed {
      logic rise;
      logic fall;
   } bit_edge_t;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/pcm_clkgen.sv
module pcm_clkgen #(
   parameter int unsigned CLK_DIV    = 75,
   parameter int unsigned FRAME_BITS = 32
) (
   input  logic clk,
   input  logic rst_n,
   output logic bclk_o,
   output logic fsync_o
);
   localparam int unsigned CW      = pcm_pkg::cnt_width(CLK_DIV);
   localparam int unsigned SW      = pcm_pkg::cnt_width(FRAME_BITS);
   localparam int unsigned HIGH_CY = CLK_DIV / 2;

   logic [CW-1:0] div_cnt, div_nxt;
   logic [SW-1:0] slot, slot_nxt;

   always_comb begin
      div_nxt  = (div_cnt == CW'(CLK_DIV - 1)) ? '0 : div_cnt + 1'b1;
      slot_nxt = slot;
      if (div_nxt == '0)
         slot_nxt = (slot == SW'(FRAME_BITS - 1)) ? '0 : slot + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt <= CW'(CLK_DIV - 1);
         slot    <= SW'(FRAME_BITS - 1);
         bclk_o  <= 1'b0;
         fsync_o <= 1'b0;
      end else begin
         div_cnt <= div_nxt;
         slot    <= slot_nxt;
         bclk_o  <= (div_nxt < CW'(HIGH_CY));
         fsync_o <= (slot_nxt == '0);
      end
   end
endmodule

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bclk_raw,
   input  logic                 fsync_raw,
   output pcm_pkg::bit_edge_t   edge_o,
   output logic                 fsync_s
);
   logic bclk_s;
   logic bclk_d;

   if (STAGES == 0) begin : g_direct
      assign bclk_s  = bclk_raw;
      assign fsync_s = fsync_raw;
   end else begin : g_sync
      logic [STAGES-1:0] b_pipe;
      logic [STAGES-1:0] f_pipe;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            b_pipe <= '0;
            f_pipe <= '0;
         end else begin
            b_pipe[0] <= bclk_raw;
            f_pipe[0] <= fsync_raw;
            for (int i = 1; i < int'(STAGES); i++) begin
               b_pipe[i] <= b_pipe[i-1];
               f_pipe[i] <= f_pipe[i-1];
            end
         end
      end
      assign bclk_s  = b_pipe[STAGES-1];
      assign fsync_s = f_pipe[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_d <= 1'b0;
      else        bclk_d <= bclk_s;
   end

   assign edge_o.rise = bclk_s & ~bclk_d;
   assign edge_o.fall = ~bclk_s & bclk_d;
endmodule

// File: rtl/pcm_frame_ctrl.sv
module pcm_frame_ctrl #(
   parameter int unsigned WORD_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  pcm_pkg::bit_edge_t edge_i,
   input  logic               fsync_s,
   output logic               frame_start,
   output logic               rx_sample,
   output logic               rx_last,
   output logic               tx_shift,
   output logic               tx_en,
   output logic               load_o
);
   localparam int unsigned BW = $clog2(WORD_W + 1);

   logic [BW-1:0] rx_left;
   logic [BW-1:0] tx_left;
   logic          tx_pend;

   assign frame_start = edge_i.fall & fsync_s & (rx_left == '0);
   assign rx_sample   = edge_i.fall & (rx_left != '0);
   assign rx_last     = rx_sample & (rx_left == BW'(1));
   assign tx_shift    = edge_i.rise & ~tx_pend & (tx_left != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_left <= '0;
         load_o  <= 1'b0;
      end else begin
         load_o <= rx_last;
         if (rx_sample)        rx_left <= rx_left - 1'b1;
         else if (frame_start) rx_left <= BW'(WORD_W);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_pend <= 1'b0;
         tx_left <= '0;
         tx_en   <= 1'b0;
      end else if (frame_start) begin
         tx_pend <= 1'b1;
      end else if (edge_i.rise) begin
         if (tx_pend) begin
            tx_pend <= 1'b0;
            tx_left <= BW'(WORD_W - 1);
            tx_en   <= 1'b1;
         end else if (tx_left != '0) begin
            tx_left <= tx_left - 1'b1;
         end else begin
            tx_en <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pcm_lane.sv
module pcm_lane #(
   parameter int unsigned WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              rx_sample,
   input  logic              rx_last,
   input  logic              tx_shift,
   input  logic              tx_en,
   input  logic              sd_i,
   input  logic [WORD_W-1:0] tx_byte,
   output logic              sd_o,
   output logic [WORD_W-1:0] rx_byte
);
   logic [WORD_W-1:0] rx_sh;
   logic [WORD_W-1:0] tx_sh;
   logic [WORD_W-1:0] rx_nxt;

   assign rx_nxt = {rx_sh[WORD_W-2:0], sd_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sh   <= '0;
         rx_byte <= '0;
      end else if (rx_sample) begin
         rx_sh <= rx_nxt;
         if (rx_last) rx_byte <= rx_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           tx_sh <= '0;
      else if (frame_start) tx_sh <= tx_byte;
      else if (tx_shift)    tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
   end

   assign sd_o = tx_en & tx_sh[WORD_W-1];
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port #(
   parameter int unsigned CLK_DIV     = 75,
   parameter int unsigned FRAME_BITS  = 32,
   parameter int unsigned WORD_W      = 8,
   parameter int unsigned NLANES      = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ext_clk_sel,
   input  logic                     bclk_in,
   input  logic                     fsync_in,
   output logic                     bclk_o,
   output logic                     fsync_o,
   input  logic [NLANES-1:0]        sd_in,
   output logic [NLANES-1:0]        sd_out,
   output logic [NLANES-1:0]        sd_oe,
   input  logic [NLANES*WORD_W-1:0] tx_bytes,
   output logic [NLANES*WORD_W-1:0] rx_bytes,
   output logic                     load_o
);
   if (CLK_DIV < 4)     begin : g_bad_div   $error("CLK_DIV must be at least 4");     end
   if (FRAME_BITS < 2)  begin : g_bad_frame $error("FRAME_BITS must be at least 2");  end
   if (WORD_W < 2)      begin : g_bad_word  $error("WORD_W must be at least 2");      end
   if (NLANES < 1)      begin : g_bad_lanes $error("NLANES must be at least 1");      end

   pcm_pkg::bit_edge_t bit_edge;
   logic bit_rise, bit_fall;
   logic fsync_s;
   logic bclk_sel, fsync_sel;
   logic frame_start, rx_sample, rx_last, tx_shift, tx_en;

   pcm_clkgen #(.CLK_DIV(CLK_DIV), .FRAME_BITS(FRAME_BITS)) u_gen (
      .clk(clk), .rst_n(rst_n), .bclk_o(bclk_o), .fsync_o(fsync_o));

   assign bclk_sel  = ext_clk_sel ? bclk_in  : bclk_o;
   assign fsync_sel = ext_clk_sel ? fsync_in : fsync_o;

   pcm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .bclk_raw(bclk_sel), .fsync_raw(fsync_sel),
      .edge_o(bit_edge), .fsync_s(fsync_s));

   assign bit_rise = bit_edge.rise;
   assign bit_fall = bit_edge.fall;

   pcm_frame_ctrl #(.WORD_W(WORD_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .edge_i(bit_edge), .fsync_s(fsync_s),
      .frame_start(frame_start), .rx_sample(rx_sample), .rx_last(rx_last),
      .tx_shift(tx_shift), .tx_en(tx_en), .load_o(load_o));

   for (genvar g = 0; g < int'(NLANES); g++) begin : g_lane
      pcm_lane #(.WORD_W(WORD_W)) u_lane (
         .clk(clk), .rst_n(rst_n),
         .frame_start(frame_start), .rx_sample(rx_sample), .rx_last(rx_last),
         .tx_shift(tx_shift), .tx_en(tx_en),
         .sd_i(sd_in[g]),
         .tx_byte(tx_bytes[g*WORD_W +: WORD_W]),
         .sd_o(sd_out[g]),
         .rx_byte(rx_bytes[g*WORD_W +: WORD_W]));
      assign sd_oe[g] = tx_en;
   end
endmodule

// File: rtl/pcm_serial_port_chk.sv
module pcm_serial_port_chk #(
   parameter int unsigned WORD_W = 8,
   parameter int unsigned NLANES = 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     bit_rise,
   input logic                     bit_fall,
   input logic                     bclk_o,
   input logic                     fsync_o,
   input logic                     load_o,
   input logic [NLANES-1:0]        sd_oe,
   input logic [NLANES-1:0]        sd_out,
   input logic [NLANES*WORD_W-1:0] rx_bytes
);
   AST_FSYNC_ON_BCLK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fsync_o) |-> $rose(bclk_o)); // R2

   AST_LOAD_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |-> $past(bit_fall)); // R3

   AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |=> !load_o); // R4

   AST_RX_HELD_BETWEEN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      !load_o |-> $stable(rx_bytes)); // R4

   AST_TX_MOVES_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_oe[0] && $past(sd_oe[0]) && !$past(bit_rise)) |-> $stable(sd_out)); // R5

   AST_OE_OPENS_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sd_oe[0]) |-> $past(bit_rise)); // R6

   AST_OUT_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ((sd_out & ~sd_oe) == '0)); // R6
endmodule

bind pcm_serial_port pcm_serial_port_chk #(.WORD_W(WORD_W), .NLANES(NLANES)) u_chk (
   .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .bit_fall(bit_fall),
   .bclk_o(bclk_o), .fsync_o(fsync_o), .load_o(load_o),
   .sd_oe(sd_oe), .sd_out(sd_out), .rx_bytes(rx_bytes));

// File: tb/pcm_serial_port_test.sv
module pcm_serial_port_test;
   localparam int CLK_PERIOD = 10;
   localparam int DIV  = 75;
   localparam int FB   = 32;
   localparam int W    = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_clk_sel = 1'b0;
   logic        bclk_in = 1'b0;
   logic        fsync_in = 1'b0;
   logic [1:0]  sd_in = '0;
   logic [15:0] tx_bytes = '0;
   logic        bclk_o, fsync_o, load_o;
   logic [1:0]  sd_out, sd_oe;
   logic [15:0] rx_bytes;

   pcm_serial_port uut (
      .clk(clk), .rst_n(rst_n), .ext_clk_sel(ext_clk_sel),
      .bclk_in(bclk_in), .fsync_in(fsync_in),
      .bclk_o(bclk_o), .fsync_o(fsync_o),
      .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe),
      .tx_bytes(tx_bytes), .rx_bytes(rx_bytes), .load_o(load_o));

   always #(CLK_PERIOD/2) clk = ~clk;

   int vectors = 0;
   int errs = 0;
   int load_cnt = 0;
   int load_wide = 0;
   logic load_prev = 1'b0;
   logic [15:0] cap_rx = '0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && load_o) begin
         load_cnt++;
         cap_rx = rx_bytes;
         if (load_prev) load_wide++;
      end
      load_prev = load_o;
   end

   // frame on the generated clock: bench acts as codec
   task automatic int_frame(input logic [7:0] a, input logic [7:0] b,
                            input logic [7:0] ta, input logic [7:0] tb);
      int lc0;
      tx_bytes = {tb, ta};
      @(posedge fsync_o); #1;
      lc0 = load_cnt;
      @(negedge bclk_o); #1;
      check("R6 oe idle in strobe slot", sd_oe, 0);
      for (int k = 1; k <= 9; k++) begin
         @(posedge bclk_o); #1;
         if (k <= 8) sd_in = {b[8-k], a[8-k]};
         @(negedge bclk_o); #1;
         if (k <= 8) begin
            check("R6 oe during data", sd_oe, 2'b11);
            check("R5 tx bit", sd_out, {tb[8-k], ta[8-k]});
         end else begin
            check("R6 oe after data", sd_oe, 0);
            check("R6 out quiet", sd_out, 0);
         end
      end
      check("R4 one load per frame", load_cnt, lc0 + 1);
      check("R3 rx bytes at load", cap_rx, {b, a});
   endtask

   // frame on the external clock, half = master cycles per clock phase
   task automatic ext_frame(input int half, input logic [7:0] a, input logic [7:0] b,
                            input logic [7:0] ta, input logic [7:0] tb,
                            input bit stray_sync, input bit change_tx);
      int lc0;
      lc0 = load_cnt;
      tx_bytes = {tb, ta};
      for (int s = 0; s <= 10; s++) begin
         bclk_in  = 1'b1;
         fsync_in = (s == 0) || (stray_sync && s == 4);
         if (s >= 1 && s <= 8) sd_in = {b[8-s], a[8-s]};
         if (change_tx && s == 3) tx_bytes = ~{tb, ta};
         repeat (half) @(posedge clk);
         #1;
         if (s >= 1 && s <= 8) begin
            check("R7 R6 oe during data", sd_oe, 2'b11);
            check("R7 R5 tx bit", sd_out, {tb[8-s], ta[8-s]});
         end else begin
            check("R6 oe outside data", sd_oe, 0);
         end
         bclk_in = 1'b0;
         repeat (half) @(posedge clk);
         #1;
      end
      fsync_in = 1'b0;
      check(stray_sync ? "R9 single load" : "R4 single load", load_cnt, lc0 + 1);
      check(stray_sync ? "R9 rx bytes" : "R7 R3 rx bytes", cap_rx, {b, a});
      check("R4 rx port holds", rx_bytes, {b, a});
      check("R4 load width", load_wide, 0);
   endtask

   task automatic measure_gen(input string tag);
      time t0, t1, t2;
      @(posedge bclk_o); t0 = $time;
      @(negedge bclk_o); t1 = $time;
      @(posedge bclk_o); t2 = $time;
      check({tag, " bclk high"}, (t1 - t0) / CLK_PERIOD, DIV / 2);
      check({tag, " bclk period"}, (t2 - t0) / CLK_PERIOD, DIV);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errs++;
      $display("FAIL watchdog R4 actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end

   initial begin
      time f0, f1, f2;
      repeat (3) @(posedge clk);
      #1;
      check("R8 bclk_o in reset", bclk_o, 0);
      check("R8 fsync_o in reset", fsync_o, 0);
      check("R8 oe in reset", sd_oe, 0);
      check("R8 out in reset", sd_out, 0);
      check("R8 load in reset", load_o, 0);
      check("R8 rx in reset", rx_bytes, 0);
      rst_n = 1'b1;

      // R1 / R2 generated clocks
      measure_gen("R1");
      @(posedge fsync_o); f0 = $time;
      @(negedge fsync_o); f1 = $time;
      @(posedge fsync_o); f2 = $time;
      check("R2 strobe high", (f1 - f0) / CLK_PERIOD, DIV);
      check("R2 strobe period", (f2 - f0) / CLK_PERIOD, DIV * FB);

      // R3 / R5 / R6 distinct patterns on the internal clock
      int_frame(8'h00, 8'hFF, 8'hFF, 8'h00);
      int_frame(8'hA5, 8'h5A, 8'h3C, 8'hC3);
      int_frame(8'h80, 8'h01, 8'h01, 8'h80);
      int_frame(8'h55, 8'hAA, 8'h96, 8'h69);

      // switch to the external clock between frames
      repeat (DIV * 10) @(posedge clk);
      ext_clk_sel = 1'b1;
      repeat (20) @(posedge clk);
      measure_gen("R7 R1");

      // R7 exhaustive byte sweep at 1.92 MHz
      for (int v = 0; v < 256; v++) begin
         ext_frame(5, 8'(v), ~8'(v), 8'(v) ^ 8'h5B, 8'(v * 3), 1'b0, 1'b0);
      end
      // R7 low end of the range, 64 kHz
      ext_frame(150, 8'hC9, 8'h36, 8'hE1, 8'h1E, 1'b0, 1'b0);
      // R9 stray strobe in mid-frame
      ext_frame(20, 8'h72, 8'h8D, 8'h4E, 8'hB1, 1'b1, 1'b0);
      // R5 transmit byte changed after the frame start
      ext_frame(20, 8'h19, 8'hE6, 8'hD4, 8'h2B, 1'b0, 1'b1);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end
endmodule